// File: doc/BRIEF.md
# Multi-mode low-power wake timer

This block is a down-counting wake-up timer driven by a slow counting tick. Software stages a load value, then commits it through a self-clearing bit of the control register. The counter drops by one on each tick of the selected source. When the count runs out, the block raises a sticky timeout event. If the system is in deep sleep at that moment, it also raises a one-cycle wake request.

Two control bits choose the behaviour at the end of a count and when counting happens. The single bit either stops the counter at zero or reloads the last committed value. The sleep-gate bit restricts decrementing to cycles where the deep-sleep input is high. The counting tick arrives as an enable pulse in the bus clock domain. A two-bit select picks one of two tick sources.

After a commit or a change of the enable bit, the block stays busy for a fixed number of cycles. This models synchronisation latency, and configuration writes are dropped during that window.

Top module: `wake_timer`

## Requirements
- R1: After reset every register reads 0, and timeout_o, wake_o, busy_o and running_o are 0.
- R2: Register map by word address: 0 is control, 1 is status, 2 is source select, 3 is staged value, 4 is live count. Select code 1 counts tick_i[0] and code 2 counts tick_i[1]. Codes 0 and 3 do not count and keep running_o at 0. Each selected tick lowers the count by one only while control bit 0 (enable) is 1; with enable at 0 the count holds.
- R3: Writing control with bit 1 set copies the staged value into the counter and into the reload register. Bit 1 reads back 1 in the cycle after the write and 0 from the next cycle on.
- R4: With control bit 3 set, ticks decrement the count only while sleep_i is 1. The count holds while sleep_i is 0.
- R5: With control bit 2 set, a tick at count 1 leaves the count at 0, sets the timeout event and clears running_o. Later ticks leave the count at 0.
- R6: With control bit 2 clear, a tick at count 1 sets the timeout event and loads the reload value. Counting then continues with running_o at 1.
- R7: A committed value of 0 sets the timeout event on the next counted tick. The counter then halts at 0 with running_o at 0, even with control bit 2 clear.
- R8: A commit or a change of the enable bit holds busy_o at 1 for SYNC_CYCLES cycles. While busy_o is 1, writes to control, source select and staged value are dropped.
- R9: The timeout event (timeout_o, status bit 2) stays set until a write to status with bit 2 at 1 clears it. Such a write is accepted even while busy.
- R10: wake_o is high for exactly one cycle after a count expiry that happens while sleep_i is 1. It stays low for an expiry while sleep_i is 0.
- R11: Status bit 0 reads busy_o and status bit 1 reads running_o. running_o is enable AND a valid source select AND not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counting clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i (combinational) |
| sleep_i | input | 1 | Deep-sleep indication |
| tick_i | input | NUM_SRC | Per-source counting tick enables |
| timeout_o | output | 1 | Sticky timeout event |
| wake_o | output | 1 | One-cycle wake request |
| busy_o | output | 1 | Configuration blocked |
| running_o | output | 1 | Timer is actively counting |

## Verification
The bench builds the block with its defaults: a 32-bit count, two tick sources and SYNC_CYCLES of 2. The two-cycle busy window allows a write issued right after a commit to land inside it, which shows that the write is dropped. Small committed values of 0, 2 and 5 reach the single-shot stop, the reload, the zero-load halt and the sleep-gated wake pulse within a few ticks each. Each source tick is also driven while the other source is selected, and while an invalid select code is set.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_CSEL = 2;
  localparam int unsigned A_VAL  = 3;
  localparam int unsigned A_CNT  = 4;

  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_SET   = 1;
  localparam int unsigned B_SGL   = 2;
  localparam int unsigned B_SLP   = 3;
  localparam int unsigned B_BUSY  = 0;
  localparam int unsigned B_RUN   = 1;
  localparam int unsigned B_TOUT  = 2;

  typedef struct packed {
    logic sleep_only;
    logic single;
    logic set;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/wt_tick_sel.sv
module wt_tick_sel #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tick_o,
  output logic               valid_o
);
  logic [NUM_SRC-1:0] hit, match;

  // code 0 means no source; code g+1 picks source g
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign match[g] = (sel_i == SEL_W'(g + 1));
    assign hit[g]   = match[g] & tick_i[g];
  end

  assign tick_o  = |hit;
  assign valid_o = |match;
endmodule

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned SYNC_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              running_i,
  input  logic              timeout_i,
  output logic [CNT_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CNT_W-1:0]  staged_o,
  output logic              commit_o,
  output logic              rearm_o,
  output logic              clr_to_o,
  output logic              busy_o
);
  localparam int unsigned BW = $clog2(SYNC_CYCLES + 1);

  ctrl_t            ctrl_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] staged_q;
  logic [BW-1:0]    busy_q;
  logic             acc, wr_ctrl, en_chg;

  assign busy_o   = (busy_q != '0);
  assign acc      = wr_en_i & ~busy_o;
  assign wr_ctrl  = acc & (addr_i == ADDR_W'(A_CTRL));
  assign commit_o = wr_ctrl & wdata_i[B_SET];
  assign en_chg   = wr_ctrl & (wdata_i[B_EN] != ctrl_q.en);
  assign rearm_o  = en_chg & wdata_i[B_EN];
  // timeout clear is never blocked by busy
  assign clr_to_o = wr_en_i & (addr_i == ADDR_W'(A_STAT)) & wdata_i[B_TOUT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      sel_q    <= '0;
      staged_q <= '0;
      busy_q   <= '0;
    end else begin
      ctrl_q.set <= commit_o;
      if (wr_ctrl) begin
        ctrl_q.en         <= wdata_i[B_EN];
        ctrl_q.single     <= wdata_i[B_SGL];
        ctrl_q.sleep_only <= wdata_i[B_SLP];
      end
      if (acc && addr_i == ADDR_W'(A_CSEL)) sel_q <= wdata_i[SEL_W-1:0];
      if (acc && addr_i == ADDR_W'(A_VAL))  staged_q <= wdata_i;
      if (commit_o || en_chg)  busy_q <= BW'(SYNC_CYCLES);
      else if (busy_o)         busy_q <= busy_q - 1'b1;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign sel_o    = sel_q;
  assign staged_o = staged_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_CTRL): rdata_o[3:0] = ctrl_q;
      ADDR_W'(A_STAT): begin
        rdata_o[B_BUSY] = busy_o;
        rdata_o[B_RUN]  = running_i;
        rdata_o[B_TOUT] = timeout_i;
      end
      ADDR_W'(A_CSEL): rdata_o[SEL_W-1:0] = sel_q;
      ADDR_W'(A_VAL):  rdata_o = staged_q;
      ADDR_W'(A_CNT):  rdata_o = cnt_i;
      default:         rdata_o = '0;
    endcase
  end

  p_set_selfclear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.set |=> !ctrl_q.set);
  p_busy_drops_val_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i && addr_i == ADDR_W'(A_VAL)) |=> staged_q == $past(staged_q));
  p_busy_drops_ctrl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i && addr_i == ADDR_W'(A_CTRL)) |=> ctrl_q.en == $past(ctrl_q.en));
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             single_i,
  input  logic             sleep_only_i,
  input  logic             sleep_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             rearm_i,
  input  logic             clr_to_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             halted_o,
  output logic             timeout_o,
  output logic             wake_o
);
  logic [CNT_W-1:0] cnt_q, reload_q;
  logic             halted_q, to_q, wake_q;
  logic             step, at_end, expire;

  assign step   = tick_i & en_i & ~halted_q & (~sleep_only_i | sleep_i) & ~load_i & ~rearm_i;
  assign at_end = (cnt_q == '0) | (cnt_q == CNT_W'(1));
  assign expire = step & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      halted_q <= 1'b0;
      to_q     <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      wake_q <= expire & sleep_i;
      if (expire)        to_q <= 1'b1;
      else if (clr_to_i) to_q <= 1'b0;
      if (load_i) begin
        cnt_q    <= load_val_i;
        reload_q <= load_val_i;
        halted_q <= 1'b0;
      end else if (rearm_i) begin
        halted_q <= 1'b0;
      end else if (step) begin
        if (!at_end) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (single_i || cnt_q == '0) begin
          // single shot, or zero load: stop instead of looping each tick
          cnt_q    <= '0;
          halted_q <= 1'b1;
        end else begin
          cnt_q <= reload_q;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign halted_o  = halted_q;
  assign timeout_o = to_q;
  assign wake_o    = wake_q;

  p_sleep_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_only_i && !sleep_i && !load_i) |=> cnt_q == $past(cnt_q));
  p_single_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && single_i && cnt_q == CNT_W'(1)) |=> (cnt_q == '0 && halted_q && to_q));
  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !single_i && cnt_q == CNT_W'(1)) |=> (cnt_q == $past(reload_q) && to_q));
  p_zero_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt_q == '0) |=> (halted_q && to_q));
  p_timeout_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_q && !clr_to_i) |=> to_q);
  p_wake_in_sleep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |-> $past(sleep_i));
  p_wake_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_q && !expire) |=> !wake_q);
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wt_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned NUM_SRC     = 2,
  parameter int unsigned SYNC_CYCLES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  input  logic               sleep_i,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic               timeout_o,
  output logic               wake_o,
  output logic               busy_o,
  output logic               running_o
);
  localparam int unsigned SEL_W = $clog2(NUM_SRC + 1);

  ctrl_t            ctrl;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] staged, cnt;
  logic             commit, rearm, clr_to, tick, sel_ok, halted;

  wt_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SYNC_CYCLES(SYNC_CYCLES)
  ) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .cnt_i(cnt), .running_i(running_o), .timeout_i(timeout_o),
    .rdata_o, .ctrl_o(ctrl), .sel_o(sel), .staged_o(staged),
    .commit_o(commit), .rearm_o(rearm), .clr_to_o(clr_to), .busy_o
  );

  wt_tick_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .tick_i, .sel_i(sel), .tick_o(tick), .valid_o(sel_ok)
  );

  wt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i(ctrl.en), .single_i(ctrl.single), .sleep_only_i(ctrl.sleep_only),
    .sleep_i, .tick_i(tick), .load_i(commit), .load_val_i(staged),
    .rearm_i(rearm), .clr_to_i(clr_to),
    .cnt_o(cnt), .halted_o(halted), .timeout_o, .wake_o
  );

  assign running_o = ctrl.en & sel_ok & ~halted;

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !commit) |=> cnt == $past(cnt));
  p_busy_after_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy_o);
endmodule

// File: tb/tb_wake_timer.sv
module tb_wake_timer;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  drv_addr = 0, mon_addr = 0, bus_addr;
  logic        mon_sel = 0, wr_en = 0, sleep = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0]  tick = 0;
  logic        timeout, wake, busy, running;
  int          n_checks = 0, n_fail = 0;
  bit          done = 0;

  typedef struct {
    bit          pins;
    logic [2:0]  addr;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  assign bus_addr = mon_sel ? mon_addr : drv_addr;
  always #(CLK_PERIOD/2) clk = ~clk;

  wake_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(bus_addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .sleep_i(sleep), .tick_i(tick),
    .timeout_o(timeout), .wake_o(wake), .busy_o(busy), .running_o(running)
  );

  // monitor: pops expected items and compares against the design
  initial forever begin
    item_t it;
    logic [31:0] got;
    wait (sb_q.size() != 0);
    it = sb_q[0];
    if (it.pins) got = {28'b0, wake, timeout, busy, running};
    else begin
      mon_sel = 1; mon_addr = it.addr; #1; got = rdata; mon_sel = 0;
    end
    n_checks++;
    if (got !== it.exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", it.req, got, it.exp);
    end
    void'(sb_q.pop_front());
  end

  task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string r);
    item_t it; it.pins = 0; it.addr = a; it.exp = e; it.req = r;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  // pins packed as {wake, timeout, busy, running}
  task automatic chk_pins(input logic [3:0] e, input string r);
    item_t it; it.pins = 1; it.addr = 0; it.exp = {28'b0, e}; it.req = r;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); drv_addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick[src] = 1;
      @(negedge clk); tick[src] = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2); rst_n = 1; idle(1);
    // R1 reset state
    chk_reg(0, 0, "R1 ctrl");
    chk_reg(1, 0, "R1 status");
    chk_reg(4, 0, "R1 count");
    chk_pins(4'b0000, "R1 pins");

    // R3 commit, R8 busy, R2 source select
    wr(3, 5); wr(2, 1);
    wr(0, 32'h3);
    chk_pins(4'b0011, "R8 busy after commit");
    chk_reg(0, 32'h3, "R3 set visible");
    idle(1);
    chk_reg(0, 32'h1, "R3 set self-clear");
    idle(2);
    chk_reg(4, 5, "R3 value loaded");
    chk_reg(1, 32'h2, "R11 status running");
    pulse(1, 1);
    chk_reg(4, 5, "R2 unselected source");
    pulse(0, 2);
    chk_reg(4, 3, "R2 selected source");
    wr(2, 3);
    pulse(0, 1); pulse(1, 1);
    chk_reg(4, 3, "R2 invalid select");
    chk_pins(4'b0000, "R11 running off");
    wr(2, 1);

    // R6 auto reload, R10 no wake when awake
    pulse(0, 3);
    chk_reg(4, 5, "R6 reloaded");
    chk_pins(4'b0101, "R6 timeout no wake");
    chk_reg(1, 32'h6, "R9 status timeout");
    wr(1, 32'h4);
    chk_pins(4'b0001, "R9 clear");

    // R4 sleep gating, R10 wake pulse
    wr(0, 32'h9);
    pulse(0, 2);
    chk_reg(4, 5, "R4 hold awake");
    sleep = 1;
    pulse(0, 2);
    chk_reg(4, 3, "R4 count asleep");
    pulse(0, 3);
    chk_pins(4'b1101, "R10 wake pulse");
    chk_reg(4, 5, "R6 reload asleep");
    idle(1);
    chk_pins(4'b0101, "R10 wake one cycle");
    sleep = 0;
    wr(1, 32'h4);

    // R5 single shot
    wr(3, 2); wr(0, 32'h7); idle(3);
    chk_reg(4, 2, "R5 loaded");
    pulse(0, 2);
    chk_reg(4, 0, "R5 stopped at zero");
    chk_pins(4'b0100, "R5 timeout halt");
    pulse(0, 1);
    chk_reg(4, 0, "R5 stays zero");
    chk_pins(4'b0100, "R9 sticky");

    // R8 writes dropped while busy
    wr(0, 32'h0);
    wr(3, 9);
    idle(3);
    chk_reg(3, 2, "R8 value write dropped");
    wr(1, 32'h4);
    chk_pins(4'b0000, "R9 cleared");

    // R7 zero load in auto mode
    wr(3, 0); wr(0, 32'h3); idle(3);
    pulse(0, 1);
    chk_pins(4'b0100, "R7 immediate timeout");
    chk_reg(4, 0, "R7 count zero");
    pulse(0, 1);
    chk_reg(4, 0, "R7 halted");

    // R2 disabled holds
    wr(3, 4); wr(0, 32'h3); idle(3);
    wr(0, 32'h0); idle(3);
    pulse(0, 2);
    chk_reg(4, 4, "R2 disabled hold");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule